// File: doc/BRIEF.md
# Write-Back Second-Level Tag Cache Controller

This block is the tag and status side of a direct-mapped second-level cache that sits between a first-level cache (upstream) and a shared bus toward cluster memory (downstream). For each of its lines it keeps a tag plus three status flags: valid, modified (dirty) and shared. A line covers four words. Data words are not stored, because only the traffic pattern between the levels is of interest. The policy is write-back with write-allocate. Write hits stay local and only mark the line dirty. Any miss brings the line in from below. If the line being replaced is dirty, its contents are written back first.

Only one upstream request is handled at a time. After a request is accepted, the lookup takes a fixed number of cycles set by a parameter. After that, the block either answers at once (hit) or runs one or two downstream transactions (optional victim write-back, then fill read) before it answers. The downstream side uses a simple request/acknowledge pair. The acknowledge of a fill also carries a shared indication, and the block stores that indication in the line.

Top module: `l2_wb_tag_cache`

## Requirements
- R1: After reset every line is invalid. `reqReady` is 1, `respValid` is 0 and `memReqValid` is 0, and the first access to any address is a miss.
- R2: A request hits when the indexed line is valid and its stored tag equals the request tag. Address layout: word offset is bits [1:0], index is the next log2(LINES) bits, tag is the rest. A hit answers with `respHit`=1 and causes no downstream request.
- R3: For a hit, `respValid` is high in the cycle that follows exactly LATENCY clock edges after the accept edge (the edge where `reqValid` and `reqReady` are both 1).
- R4: A write hit sets the line's modified flag with no downstream traffic. When that line is later replaced, it is written back.
- R5: On a miss whose indexed line is valid and modified, the block first issues a write (`memReqWrite`=1) to the victim address {stored tag, index, 2'b00}. Only after that write is acknowledged does it issue the fill read.
- R6: On a miss whose indexed line is invalid or clean, the block issues only a fill read (`memReqWrite`=0) to the request address with bits [1:0] forced to zero.
- R7: A write miss allocates. It fetches the line with a fill read, answers `respHit`=0, and leaves the line modified.
- R8: A fill taken for a read leaves the line clean. The line's shared flag is loaded from `memShared` at the acknowledging edge, and `respShared` reports the line's shared flag on every response.
- R9: While `memReqValid` is 1 and `memAck` is 0, `memReqValid`, `memReqWrite` and `memReqAddr` hold their values into the next cycle.
- R10: `reqReady` is 0 from the accept edge until the response cycle has ended. `respValid` is a single-cycle pulse, and `reqReady` is 0 while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Upstream request present |
| reqReady | output | 1 | Block is idle and will accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Upstream word address |
| respValid | output | 1 | One-cycle response pulse |
| respHit | output | 1 | Response was a hit |
| respShared | output | 1 | Shared flag of the addressed line at response |
| memReqValid | output | 1 | Downstream request active |
| memReqWrite | output | 1 | 1 = victim write-back, 0 = fill read |
| memReqAddr | output | ADDR_W | Line address of the downstream request |
| memAck | input | 1 | Downstream acknowledge of the current request |
| memShared | input | 1 | Shared indication returned with a fill acknowledge |

## Verification
Two events can land on the same clock edge: the acknowledge that completes a downstream transaction, and the capture of a line update. The write-back acknowledge and the switch to the fill read share one edge. The fill acknowledge and the tag/status install (including the shared flag taken from `memShared`) also share one edge. A test memory that can acknowledge in the very first cycle a request appears brings these together, and a slower setting (three wait cycles) is used for contrast. At the same time, a driver keeps `reqValid` asserted straight after each response. A reference model predicts the exact order and addresses of downstream transactions and the hit, shared and latency of each response, and these are compared in arrival order.

// File: rtl/l2tc_pkg.sv
package l2tc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WBACK,
    ST_FILL,
    ST_RESP
  } ctlState_t;

  // strobes from control to the tag/status datapath
  typedef struct packed {
    logic capture;    // latch the incoming request
    logic markDirty;  // write hit: set modified on the current line
    logic install;    // fill acknowledged: load tag and status
  } dpStrobe_t;

endpackage

// File: rtl/l2tc_tagpath.sv
module l2tc_tagpath
  import l2tc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LINES  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              memShared,
  output logic              hit,
  output logic              victimDirty,
  output logic              isWrite,
  output logic [ADDR_W-1:0] victimAddr,
  output logic [ADDR_W-1:0] fillAddr,
  output logic              lineShared
);

  localparam int OFF_W = 2;
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [ADDR_W-1:0] curAddr;
  logic              curWrite;
  logic [IDX_W-1:0]  curIdx;
  logic [TAG_W-1:0]  curTag;

  logic [LINES-1:0]  validV;
  logic [LINES-1:0]  modV;
  logic [LINES-1:0]  shrV;
  logic [TAG_W-1:0]  tagMem [LINES];

  assign curIdx = curAddr[OFF_W +: IDX_W];
  assign curTag = curAddr[ADDR_W-1 -: TAG_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      curWrite <= 1'b0;
    end else if (strb.capture) begin
      curAddr  <= reqAddr;
      curWrite <= reqWrite;
    end
  end

  // per-line status flags, each with its own select
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic sel;
    assign sel = (curIdx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validV[i] <= 1'b0;
        modV[i]   <= 1'b0;
        shrV[i]   <= 1'b0;
      end else if (sel && strb.install) begin
        validV[i] <= 1'b1;
        modV[i]   <= curWrite;
        shrV[i]   <= memShared;
      end else if (sel && strb.markDirty) begin
        modV[i]   <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel && strb.install) tagMem[i] <= curTag;
    end
  end

  assign hit         = validV[curIdx] && (tagMem[curIdx] == curTag);
  assign victimDirty = validV[curIdx] && modV[curIdx];
  assign isWrite     = curWrite;
  assign victimAddr  = {tagMem[curIdx], curIdx, {OFF_W{1'b0}}};
  assign fillAddr    = {curTag, curIdx, {OFF_W{1'b0}}};
  assign lineShared  = shrV[curIdx];

endmodule

// File: rtl/l2tc_ctl.sv
module l2tc_ctl
  import l2tc_pkg::*;
#(
  parameter int LATENCY = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      hit,
  input  logic      victimDirty,
  input  logic      isWrite,
  input  logic      memAck,
  output logic      reqReady,
  output logic      respValid,
  output logic      respHit,
  output logic      memReqValid,
  output logic      memReqWrite,
  output logic      selVictim,
  output dpStrobe_t strb
);

  localparam int CNT_W = $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LATENCY - 1);

  ctlState_t        state, nextState;
  logic [CNT_W-1:0] waitCnt;
  logic             hitReg;
  logic             lookDone;

  assign lookDone = (state == ST_LOOK) && (waitCnt == LAST);

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strb.capture = 1'b1;
          nextState    = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (lookDone) begin
          if (hit) begin
            strb.markDirty = isWrite;
            nextState      = ST_RESP;
          end else if (victimDirty) begin
            nextState = ST_WBACK;
          end else begin
            nextState = ST_FILL;
          end
        end
      end
      ST_WBACK: if (memAck) nextState = ST_FILL;
      ST_FILL: begin
        if (memAck) begin
          strb.install = 1'b1;
          nextState    = ST_RESP;
        end
      end
      ST_RESP:  nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      hitReg  <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_LOOK) waitCnt <= waitCnt + 1'b1;
      else                  waitCnt <= '0;
      if (lookDone) hitReg <= hit;
    end
  end

  assign reqReady    = (state == ST_IDLE);
  assign respValid   = (state == ST_RESP);
  assign respHit     = respValid && hitReg;
  assign memReqValid = (state == ST_WBACK) || (state == ST_FILL);
  assign memReqWrite = (state == ST_WBACK);
  assign selVictim   = (state == ST_WBACK);

endmodule

// File: rtl/l2_wb_tag_cache.sv
module l2_wb_tag_cache
  import l2tc_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LINES   = 16,
  parameter int LATENCY = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              respValid,
  output logic              respHit,
  output logic              respShared,
  output logic              memReqValid,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memAck,
  input  logic              memShared
);

  dpStrobe_t         strb;
  logic              hit, victimDirty, isWrite, lineShared, selVictim;
  logic [ADDR_W-1:0] victimAddr, fillAddr;

  l2tc_tagpath #(.ADDR_W(ADDR_W), .LINES(LINES)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .memShared(memShared),
    .hit(hit), .victimDirty(victimDirty), .isWrite(isWrite),
    .victimAddr(victimAddr), .fillAddr(fillAddr), .lineShared(lineShared)
  );

  l2tc_ctl #(.LATENCY(LATENCY)) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .hit(hit), .victimDirty(victimDirty), .isWrite(isWrite), .memAck(memAck),
    .reqReady(reqReady), .respValid(respValid), .respHit(respHit),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .selVictim(selVictim), .strb(strb)
  );

  assign memReqAddr = selVictim ? victimAddr : fillAddr;
  assign respShared = respValid && lineShared;

endmodule

// File: rtl/l2tc_checker.sv
module l2tc_checker #(
  parameter int ADDR_W  = 16,
  parameter int LATENCY = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              respValid,
  input logic              respHit,
  input logic              memReqValid,
  input logic              memReqWrite,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memAck
);

  logic [7:0] sinceAccept;

  always_ff @(posedge clk) begin
    if (!rstN)                     sinceAccept <= '0;
    else if (reqValid && reqReady) sinceAccept <= '0;
    else if (sinceAccept != 8'hFF) sinceAccept <= sinceAccept + 1'b1;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReqValid && !respValid);

  assert_hit_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respHit) |-> (32'(sinceAccept) == LATENCY));

  assert_wb_then_fill_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite && memAck) |=> (memReqValid && !memReqWrite));

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memAck) |=>
      (memReqValid && $stable(memReqAddr) && $stable(memReqWrite)));

  assert_resp_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);

  assert_busy_on_resp_R10: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !reqReady);

endmodule

bind l2_wb_tag_cache l2tc_checker #(.ADDR_W(ADDR_W), .LATENCY(LATENCY)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .respValid(respValid), .respHit(respHit), .memReqValid(memReqValid),
  .memReqWrite(memReqWrite), .memReqAddr(memReqAddr), .memAck(memAck)
);

// File: tb/l2_wb_tag_cache_test.sv
`timescale 1ns/100ps
module l2_wb_tag_cache_test;
  localparam int AW = 16, NL = 16, LAT = 2;

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWrite = 0, memAck = 0, memShared = 0;
  logic [AW-1:0] reqAddr = '0;
  logic reqReady, respValid, respHit, respShared, memReqValid, memReqWrite;
  logic [AW-1:0] memReqAddr;

  always #2.5 clk = ~clk;

  l2_wb_tag_cache #(.ADDR_W(AW), .LINES(NL), .LATENCY(LAT)) uut (.*);

  int checks = 0, fails = 0, cyc = 0, acceptCyc = 0, memDelay = 1, waitCnt = 0;
  bit finished = 0;

  // reference model
  bit          mValid [NL];
  bit          mMod   [NL];
  bit          mShr   [NL];
  logic [9:0]  mTag   [NL];

  // expected queues
  bit          expMemWr[$];
  logic [AW-1:0] expMemAd[$];
  string       expMemTag[$];
  bit          expHit[$];
  bit          expShr[$];
  string       expRspTag[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit sharedOf(input logic [AW-1:0] a);
    return ^a[7:4];
  endfunction

  task automatic access(input bit w, input logic [AW-1:0] a);
    int idx = int'(a[5:2]);
    logic [9:0] tg = a[15:6];
    logic [AW-1:0] fa = {tg, a[5:2], 2'b00};
    if (mValid[idx] && mTag[idx] == tg) begin
      if (w) mMod[idx] = 1;
      expHit.push_back(1); expShr.push_back(mShr[idx]);
      expRspTag.push_back(w ? "R4" : "R2/R3");
    end else begin
      if (mValid[idx] && mMod[idx]) begin
        expMemWr.push_back(1); expMemAd.push_back({mTag[idx], a[5:2], 2'b00});
        expMemTag.push_back("R5");
      end
      expMemWr.push_back(0); expMemAd.push_back(fa);
      expMemTag.push_back(w ? "R7" : "R6");
      mValid[idx] = 1; mTag[idx] = tg; mMod[idx] = w; mShr[idx] = sharedOf(fa);
      expHit.push_back(0); expShr.push_back(mShr[idx]);
      expRspTag.push_back(w ? "R7" : "R8");
    end
    @(posedge clk); #1;
    reqValid = 1; reqWrite = w; reqAddr = a;
    do @(negedge clk); while (!reqReady);
    @(posedge clk); #1;
    reqValid = 0;
  endtask

  // downstream responder
  always @(posedge clk) begin
    #1;
    if (!rstN) begin memAck = 0; waitCnt = 0; end
    else if (memAck) begin memAck = 0; waitCnt = 0; end
    else if (memReqValid) begin
      if (waitCnt >= memDelay) begin memAck = 1; memShared = sharedOf(memReqAddr); end
      else waitCnt++;
    end
  end

  // monitor
  bit prevResp = 0, prevPend = 0, prevWr = 0;
  logic [AW-1:0] prevAd = '0;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevPend)
        chk(memReqValid && memReqWrite == prevWr && memReqAddr == prevAd, "R9",
            "held request", int'(memReqAddr), int'(prevAd));
      if (respValid) begin
        chk(!prevResp && !reqReady, "R10", "pulse/busy", int'(prevResp), 0);
        if (expHit.size() == 0) chk(0, "R2", "unexpected response", 1, 0);
        else begin
          automatic bit h = expHit.pop_front();
          automatic bit s = expShr.pop_front();
          automatic string t = expRspTag.pop_front();
          chk(respHit == h, t, "respHit", int'(respHit), int'(h));
          chk(respShared == s, "R8", "respShared", int'(respShared), int'(s));
          if (h) chk(cyc - acceptCyc == LAT + 1, "R3", "hit latency",
                     cyc - acceptCyc, LAT + 1);
        end
      end
      if (memReqValid && memAck) begin
        if (expMemWr.size() == 0) chk(0, "R2", "unexpected downstream", int'(memReqAddr), 0);
        else begin
          automatic bit ew = expMemWr.pop_front();
          automatic logic [AW-1:0] ea = expMemAd.pop_front();
          automatic string t = expMemTag.pop_front();
          chk(memReqWrite == ew, t, "memReqWrite", int'(memReqWrite), int'(ew));
          chk(memReqAddr == ea, t, "memReqAddr", int'(memReqAddr), int'(ea));
        end
      end
      if (reqValid && reqReady) acceptCyc = cyc;
      prevResp = respValid;
      prevPend = memReqValid && !memAck;
      prevWr = memReqWrite; prevAd = memReqAddr;
    end
    cyc++;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    automatic int unsigned seed = 32'h1234_5678;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    chk(reqReady && !respValid && !memReqValid, "R1", "reset state",
        int'({reqReady, respValid, memReqValid}), 4);
    // directed sequence
    access(0, 16'h0041);  // cold miss, clean fill (R1, R6)
    access(0, 16'h0042);  // hit
    access(1, 16'h0043);  // write hit, dirty, no traffic (R4)
    access(0, 16'h1040);  // dirty victim: write-back 0x0040 then fill (R5)
    access(1, 16'h2085);  // write miss allocates (R7)
    access(0, 16'h3084);  // evicts dirty write-allocated line
    access(0, 16'h5040);  // victim 0x1040 clean after read fill (R8)
    memDelay = 0;         // acknowledge in the first request cycle
    access(1, 16'h5041);
    access(0, 16'h7040);
    access(1, 16'h00FC);
    access(0, 16'h00FD);
    memDelay = 3;
    access(1, 16'h40FC);
    access(0, 16'h00FC);
    for (int i = 0; i < 300; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      memDelay = int'(seed[30:29]);
      access(seed[16], {6'h00, seed[25:24], seed[11:4]});
    end
    repeat (20) @(posedge clk);
    chk(expHit.size() == 0 && expMemWr.size() == 0, "R10", "queues drained",
        expHit.size(), 0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule